// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This controller sits between a synchronous request port and an external asynchronous static RAM. The RAM is built from four 8-bit lanes that share one 19-bit address and one active-low output enable. Each lane has its own active-low chip select and active-low write enable. A request carries a direction, a 21-bit word address, 32 bits of write data and four byte enables. The controller then generates the address, lane selects, strobes and data-bus drive with cycle-exact pulse widths, and it reports completion with a one-cycle done pulse.

A two-bit width mode makes the same array look like a 32-bit, 16-bit or 8-bit memory. In the narrower modes the lowest request address bits pick the lane pair or the single lane, and the remaining bits form the RAM address. Every pulse length is a whole number of clock cycles. Each one is derived by rounding up the ratio of a timing parameter to the clock-period parameter. The data bus appears as separate output, output-enable and input vectors, and the pad ring combines them.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While rst_ni is low and right after reset, all chip selects and write enables are high, the output enable is high, the bus is not driven, done_o is low and req_ready_o is high.
- R2: Mode 2'b00 (32-bit): the RAM address is req_addr_i[18:0], and higher bits are ignored. A write pulls chip select and write enable low on exactly the lanes whose req_be_i bit is set, and the output enable stays high. Lane n carries req_wdata_i[8n+7:8n]. The bus is driven for as long as any write enable is low.
- R3: With the default timing (5 ns clock, 10 ns pulse, 8 ns data setup, 12 ns cycle), write strobes stay low for exactly 2 cycles. Data remains driven for one cycle after the strobes rise, and done_o follows in that cycle.
- R4: A 32-bit read pulls all four chip selects and the output enable low, with write enables high, for exactly 3 cycles (12 ns access time rounded up). The bus is then sampled into rdata_o, which is valid in the cycle done_o is high.
- R5: Mode 2'b01 (16-bit): the RAM address is req_addr_i[19:1]. req_addr_i[0]=0 selects lanes 0-1 and 1 selects lanes 2-3. Write data req_wdata_i[15:0] goes to both pairs, and req_be_i[1:0] gate the lower and upper lane of the pair. Read data returns in rdata_o[15:0] with the upper half zero.
- R6: Mode 2'b10 (8-bit): the RAM address is req_addr_i[20:2] and req_addr_i[1:0] selects one lane. req_wdata_i[7:0] is placed on every lane, req_be_i[0] gates the write, and read data returns in rdata_o[7:0] with the rest zero.
- R7: Mode 2'b11 behaves exactly like the 32-bit mode.
- R8: The bus is never driven while the output enable is low. After a read, req_ready_o stays low for 2 cycles after done_o (7 ns float time rounded up), with the bus undriven.
- R9: A write enable is only low on a lane whose chip select is low, and never while the output enable is low.
- R10: done_o lasts one cycle. req_ready_o is low from the accepting edge until the request completes.
- R11: A write with all byte enables clear asserts no chip select or write enable, leaves memory contents unchanged, and still completes with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Width mode, sampled when a request is accepted |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 21 | Request address in units of the current width |
| req_wdata_i | input | 32 | Write data, right-aligned in narrow modes |
| req_be_i | input | 4 | Byte enables, right-aligned in narrow modes |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, right-aligned, held until the next read |
| sram_addr_o | output | 19 | RAM address |
| sram_cs_n_o | output | 4 | Per-lane chip select, active low |
| sram_we_n_o | output | 4 | Per-lane write enable, active low |
| sram_oe_n_o | output | 1 | Shared output enable, active low |
| sram_dq_o | output | 32 | Bus data to drive |
| sram_dq_oe_o | output | 1 | Bus drive enable |
| sram_dq_i | input | 32 | Bus data from the pads |

## Verification
Full-word writes and reads in 32-bit mode establish the basic address and strobe timing. Partial and empty byte masks then show that write gating is per lane and that an empty mask writes nothing. Pair writes in 16-bit mode with both values of the low address bit are read back as full words to show which lanes were touched. Four consecutive byte writes in 8-bit mode are read back as one packed word, which distinguishes the lane order from the address shift. The reserved mode is compared against the 32-bit results, and each read is followed by a check of the turnaround stall before the next request.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [1:0] {
    WM_32  = 2'b00,
    WM_16  = 2'b01,
    WM_8   = 2'b10,
    WM_RSV = 2'b11
  } width_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_TURN
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANE_W = 8,
  localparam int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W,
  localparam int REQ_AW = ADDR_W + 2
) (
  input  width_mode_e       mode_i,
  input  logic [REQ_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [LANES-1:0]  lane_rd_o,
  output logic [LANES-1:0]  lane_wr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int HALF_W = 2 * LANE_W;

  always_comb begin
    unique case (mode_i)
      WM_16:   ram_addr_o = addr_i[ADDR_W:1];
      WM_8:    ram_addr_o = addr_i[ADDR_W+1:2];
      default: ram_addr_o = addr_i[ADDR_W-1:0];
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic pair_hit, byte_hit;
    assign pair_hit = ((l / 2) == int'(addr_i[0]));
    assign byte_hit = (l == int'(addr_i[1:0]));

    always_comb begin
      unique case (mode_i)
        WM_16: begin
          lane_rd_o[l] = pair_hit;
          lane_wr_o[l] = pair_hit & be_i[l % 2];
          wdata_o[l*LANE_W +: LANE_W] = wdata_i[(l % 2)*LANE_W +: LANE_W];
        end
        WM_8: begin
          lane_rd_o[l] = byte_hit;
          lane_wr_o[l] = byte_hit & be_i[0];
          wdata_o[l*LANE_W +: LANE_W] = wdata_i[LANE_W-1:0];
        end
        default: begin
          lane_rd_o[l] = 1'b1;
          lane_wr_o[l] = be_i[l];
          wdata_o[l*LANE_W +: LANE_W] = wdata_i[l*LANE_W +: LANE_W];
        end
      endcase
    end
  end

  logic unused_half;
  assign unused_half = (HALF_W == 0);
endmodule

// File: rtl/sram_read_align.sv
module sram_read_align
  import sram_lane_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W,
  localparam int HALF_W = 2 * LANE_W
) (
  input  width_mode_e       mode_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] word_o
);
  logic [1:0][HALF_W-1:0]       halves;
  logic [LANES-1:0][LANE_W-1:0] bytes;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = dq_i[h*HALF_W +: HALF_W];
  end
  for (genvar b = 0; b < LANES; b++) begin : g_byte
    assign bytes[b] = dq_i[b*LANE_W +: LANE_W];
  end

  always_comb begin
    unique case (mode_i)
      WM_16:   word_o = DATA_W'(halves[sel_i[0]]);
      WM_8:    word_o = DATA_W'(bytes[sel_i]);
      default: word_o = dq_i;
    endcase
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 3,
  parameter int TA_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_rd_i,
  input  logic [LANES-1:0]  lane_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              capture_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [LANES-1:0]  cs_n_o,
  output logic [LANES-1:0]  we_n_o,
  output logic              oe_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int MAX_CYC = max3(WR_CYC, RD_CYC, TA_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign ready_o   = (state_q == ST_IDLE);
  assign capture_o = (state_q == ST_RD) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sram_addr_o <= '0;
      cs_n_o      <= '1;
      we_n_o      <= '1;
      oe_n_o      <= 1'b1;
      dq_o        <= '0;
      dq_oe_o     <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sram_addr_o <= addr_i;
          if (write_i) begin
            cs_n_o  <= ~lane_wr_i;
            we_n_o  <= ~lane_wr_i;
            dq_o    <= wdata_i;
            dq_oe_o <= 1'b1;
            cnt_q   <= CNT_W'(WR_CYC - 1);
            state_q <= ST_WR;
          end else begin
            cs_n_o  <= ~lane_rd_i;
            oe_n_o  <= 1'b0;
            cnt_q   <= CNT_W'(RD_CYC - 1);
            state_q <= ST_RD;
          end
        end
        ST_WR: begin
          if (cnt_zero) begin
            cs_n_o  <= '1;
            we_n_o  <= '1;
            state_q <= ST_WREC;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WREC: begin
          // data held one cycle past the strobe edge
          dq_oe_o <= 1'b0;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RD: begin
          if (cnt_zero) begin
            cs_n_o  <= '1;
            oe_n_o  <= 1'b1;
            done_o  <= 1'b1;
            cnt_q   <= CNT_W'(TA_CYC - 1);
            state_q <= ST_TURN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt_zero) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r8_no_drive_under_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !dq_oe_o);
  a_r8_quiet_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_n_o) |=> !dq_oe_o);
  a_r9_we_within_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~we_n_o) & cs_n_o) == '0);
  a_r9_we_oe_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_n_o != '1) |-> oe_n_o);
  a_r2_drive_during_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_n_o != '1) |-> dq_oe_o);
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int LANE_W   = 8,
  parameter int CLK_PS   = 5000,
  parameter int T_AA_PS  = 12000,
  parameter int T_OE_PS  = 7000,
  parameter int T_WP_PS  = 10000,
  parameter int T_DW_PS  = 8000,
  parameter int T_WC_PS  = 12000,
  parameter int T_HZ_PS  = 7000,
  localparam int LANES   = 4,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int REQ_AW  = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [REQ_AW-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [LANES-1:0]  sram_cs_n_o,
  output logic [LANES-1:0]  sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  // write cycle = pulse + one recovery cycle
  localparam int WR_CYC = max3(ceil_div(T_WP_PS, CLK_PS), ceil_div(T_DW_PS, CLK_PS),
                               ceil_div(T_WC_PS, CLK_PS) - 1);
  localparam int RD_CYC = max3(ceil_div(T_AA_PS, CLK_PS), ceil_div(T_OE_PS, CLK_PS), 1);
  localparam int TA_CYC = max3(ceil_div(T_HZ_PS, CLK_PS), 1, 1);

  width_mode_e       mode, mode_q;
  logic [1:0]        sel_q;
  logic              start, capture;
  logic [ADDR_W-1:0] map_addr;
  logic [LANES-1:0]  lane_rd, lane_wr;
  logic [DATA_W-1:0] map_wdata, aligned;

  assign mode  = width_mode_e'(mode_i);
  assign start = req_valid_i & req_ready_o;

  sram_lane_map #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_map (
    .mode_i    (mode),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .be_i      (req_be_i),
    .ram_addr_o(map_addr),
    .lane_rd_o (lane_rd),
    .lane_wr_o (lane_wr),
    .wdata_o   (map_wdata)
  );

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .write_i    (req_write_i),
    .addr_i     (map_addr),
    .lane_rd_i  (lane_rd),
    .lane_wr_i  (lane_wr),
    .wdata_i    (map_wdata),
    .ready_o    (req_ready_o),
    .capture_o  (capture),
    .done_o     (done_o),
    .sram_addr_o(sram_addr_o),
    .cs_n_o     (sram_cs_n_o),
    .we_n_o     (sram_we_n_o),
    .oe_n_o     (sram_oe_n_o),
    .dq_o       (sram_dq_o),
    .dq_oe_o    (sram_dq_oe_o)
  );

  sram_read_align #(.LANE_W(LANE_W)) u_align (
    .mode_i(mode_q),
    .sel_i (sel_q),
    .dq_i  (sram_dq_i),
    .word_o(aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= WM_32;
      sel_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (start) begin
        mode_q <= mode;
        sel_q  <= req_addr_i[1:0];
      end
      if (capture) rdata_o <= aligned;
    end
  end

  a_r6_one_lane_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WM_8 && !sram_oe_n_o) |-> ($countones(~sram_cs_n_o) == 1));
  a_r5_pair_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WM_16 && !sram_oe_n_o) |-> ($countones(~sram_cs_n_o) == 2));
  a_r4_full_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == WM_32 || mode_q == WM_RSV) && !sram_oe_n_o) |-> (sram_cs_n_o == '0));
endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int WR_LEN = 2;
  localparam int RD_LEN = 3;

  typedef struct {
    bit          wr;
    logic [18:0] addr;
    logic [3:0]  cs_n;
    logic [3:0]  we_n;
    logic [31:0] rdata;
    int          len;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        valid = 1'b0, write = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        ready, done, oe_n, dq_oe;
  logic [31:0] rdata, dq_o, dq_i;
  logic [18:0] sram_addr;
  logic [3:0]  cs_n, we_n;

  int n_chk = 0, n_fail = 0;
  item_t q[$];
  logic [7:0] mem    [4][1024];
  logic [7:0] shadow [4][1024];

  always #2.5 clk = ~clk;

  sram_lane_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_be_i(be),
    .done_o(done), .rdata_o(rdata),
    .sram_addr_o(sram_addr), .sram_cs_n_o(cs_n), .sram_we_n_o(we_n),
    .sram_oe_n_o(oe_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // RAM lane model: read data valid immediately, controller waits the access time
  for (genvar l = 0; l < 4; l++) begin : g_model
    assign dq_i[l*8 +: 8] = (!cs_n[l] && we_n[l] && !oe_n) ? mem[l][sram_addr[9:0]] : 8'h00;
  end
  always @(posedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!cs_n[l] && !we_n[l]) mem[l][sram_addr[9:0]] <= dq_o[l*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: strobe shape and read data against queued expectations
  int  act_len = 0;
  bit  shape_bad = 0, drive_bad = 0, prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n && dq_oe) drive_bad = 1;
      if (cs_n != 4'hF) begin
        act_len++;
        if (q.size() > 0) begin
          if (sram_addr != q[0].addr || cs_n != q[0].cs_n || we_n != q[0].we_n ||
              oe_n != q[0].wr) shape_bad = 1;
          if (we_n != 4'hF && !dq_oe) shape_bad = 1;
        end
      end
      if (done) begin
        if (prev_done) chk(0, "R10 done width", 32'd2, 32'd1);
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          chk(!shape_bad && act_len == it.len, {it.tag, " strobes"}, act_len, it.len);
          if (!it.wr) chk(rdata == it.rdata, {it.tag, " rdata"}, rdata, it.rdata);
          chk(!drive_bad, "R8 drive vs oe", 32'(drive_bad), 32'd0);
        end else chk(0, "R10 unexpected done", 32'd1, 32'd0);
        act_len = 0; shape_bad = 0; drive_bad = 0;
      end
      prev_done = done;
    end
  end

  task automatic xfer(input bit wr, input logic [1:0] md, input logic [20:0] a,
                      input logic [31:0] d, input logic [3:0] b, input string tag);
    item_t it;
    logic [18:0] ra;
    logic [3:0]  rd_l, wr_l;
    logic [31:0] word;
    unique case (md)
      2'b01: begin ra = a[19:1]; rd_l = a[0] ? 4'b1100 : 4'b0011; wr_l = rd_l & {b[1:0], b[1:0]}; end
      2'b10: begin ra = a[20:2]; rd_l = 4'b0001 << a[1:0]; wr_l = b[0] ? rd_l : 4'b0000; end
      default: begin ra = a[18:0]; rd_l = 4'hF; wr_l = b; end
    endcase
    it.wr = wr; it.addr = ra; it.tag = tag; it.rdata = '0;
    if (wr) begin
      it.cs_n = ~wr_l; it.we_n = ~wr_l; it.len = (wr_l != 0) ? WR_LEN : 0;
      for (int l = 0; l < 4; l++)
        if (wr_l[l])
          shadow[l][ra[9:0]] = (md == 2'b01) ? d[(l%2)*8 +: 8] :
                               (md == 2'b10) ? d[7:0] : d[l*8 +: 8];
    end else begin
      it.cs_n = ~rd_l; it.we_n = 4'hF; it.len = RD_LEN;
      for (int l = 0; l < 4; l++) word[l*8 +: 8] = shadow[l][ra[9:0]];
      it.rdata = (md == 2'b01) ? {16'h0, a[0] ? word[31:16] : word[15:0]} :
                 (md == 2'b10) ? {24'h0, word[a[1:0]*8 +: 8]} : word;
    end
    q.push_back(it);
    while (!ready) @(negedge clk);
    valid = 1'b1; write = wr; mode = md; addr = a; wdata = d; be = b;
    @(negedge clk);
    valid = 1'b0;
    chk(!ready, {tag, " R10 busy"}, 32'(ready), 32'd0);
    while (!done) @(negedge clk);
    if (wr) begin
      chk(ready && !dq_oe, {tag, " R3 write release"}, {30'd0, ready, dq_oe}, 32'd2);
    end else begin
      chk(!ready && !dq_oe, {tag, " R8 turnaround 0"}, {30'd0, ready, dq_oe}, 32'd0);
      @(negedge clk);
      chk(!ready && !dq_oe, {tag, " R8 turnaround 1"}, {30'd0, ready, dq_oe}, 32'd0);
      @(negedge clk);
      chk(ready, {tag, " R8 ready after turn"}, 32'(ready), 32'd1);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF && we_n == 4'hF && oe_n && !dq_oe && !done && ready, "R1 in reset",
        {cs_n, we_n, 20'd0, oe_n, dq_oe, done, ready}, 32'hFF000009);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF && we_n == 4'hF && oe_n && !dq_oe && !done && ready, "R1 after reset",
        {cs_n, we_n, 20'd0, oe_n, dq_oe, done, ready}, 32'hFF000009);

    xfer(1, 2'b00, 21'h012345, 32'hDEADBEEF, 4'hF, "R2 R3 full write");
    xfer(0, 2'b00, 21'h012345, 32'h0, 4'h0, "R4 full read");
    xfer(1, 2'b00, 21'h012345, 32'h11223344, 4'b0101, "R2 partial write");
    xfer(0, 2'b00, 21'h012345, 32'h0, 4'h0, "R2 partial readback");
    xfer(1, 2'b00, 21'h012345, 32'hFFFFFFFF, 4'h0, "R11 empty write");
    xfer(0, 2'b00, 21'h012345, 32'h0, 4'h0, "R11 unchanged");

    xfer(1, 2'b00, 21'h000155, 32'h01020304, 4'hF, "R5 base word");
    xfer(1, 2'b01, 21'h0002AB, 32'h0000CAFE, 4'b0011, "R5 upper pair write");
    xfer(0, 2'b01, 21'h0002AB, 32'h0, 4'h0, "R5 upper pair read");
    xfer(0, 2'b01, 21'h0002AA, 32'h0, 4'h0, "R5 lower pair read");
    xfer(0, 2'b00, 21'h000155, 32'h0, 4'h0, "R5 word view");
    xfer(1, 2'b01, 21'h0002AA, 32'h0000AB99, 4'b0010, "R5 high byte only");
    xfer(0, 2'b00, 21'h000155, 32'h0, 4'h0, "R5 word after byte");

    for (int k = 0; k < 4; k++)
      xfer(1, 2'b10, 21'h000280 + 21'(k), 32'(8'h10 + 8'h11 * k), 4'b0001, "R6 byte write");
    xfer(0, 2'b00, 21'h0000A0, 32'h0, 4'h0, "R6 packed word");
    xfer(0, 2'b10, 21'h000282, 32'h0, 4'h0, "R6 byte read");
    xfer(1, 2'b10, 21'h000283, 32'h000000FF, 4'b1110, "R6 R11 be0 clear");
    xfer(0, 2'b10, 21'h000283, 32'h0, 4'h0, "R6 byte unchanged");

    xfer(1, 2'b11, 21'h1F0011, 32'h5A5AA5A5, 4'hF, "R7 reserved write");
    xfer(0, 2'b11, 21'h1F0011, 32'h0, 4'h0, "R7 reserved read");
    xfer(0, 2'b00, 21'h070011, 32'h0, 4'h0, "R7 R2 same word");

    chk(q.size() == 0, "R10 pending items", 32'(q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10 act=%h exp=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule